// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block holds an interrupt-enable register and an interrupt-status register for each locality of a multi-locality security-module interface, and drives one interrupt request line shared by all of them. Elsewhere in the interface, logic produces single-cycle event pulses: data-available, status-valid, locality-changed and command-ready. Each pulse carries the number of the locality it is meant for. A pulse is recorded in that locality's status register, and the shared line is raised, only when that locality has both its global enable and the enable for that event set.

Software acknowledges an event by writing ones to status bits. Only the locality that currently owns the interface may change its enable and status registers. The block also returns a fixed interrupt vector number. It holds an interrupt-select lock flag in the interface-identification register, and all localities see the same copy of that flag.

The line comes from a two-state machine. In `LINE_IDLE` the request is low. Any recorded event moves it to `LINE_RAISED`. A status write that leaves the writing locality's status at zero moves it back to `LINE_IDLE`. If both happen in the same cycle, the recorded event wins and the machine stays in or enters `LINE_RAISED`.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset, every enable register reads 0x0000_0008 (low-level polarity, all enables off), every status register reads 0, the line is low and the lock flag (bit 19 of the interface-ID register) reads 0.
- R2: An event pulse sets its status bit and raises the line at the next clock edge only if the target locality's enable has both bit 31 (global) and the event's own bit set. Event bit positions are data-available bit 0, status-valid bit 1, locality-changed bit 2 and command-ready bit 7. Pulse index 0..3 maps to these bits in that order.
- R3: An event tagged with a locality number of NUM_LOC or above changes no register and does not raise the line.
- R4: Events that reach the same locality in the same cycle are OR-merged into its status register.
- R5: A write to an enable or status register takes effect only when `active_valid` is high and `reg_loc` equals `active_loc`. Any other write to these registers has no effect.
- R6: An enable write changes only the byte lanes whose `reg_be` bit is set. Within those lanes, only bits 31, 7, 4:3 and 2:0 can become 1.
- R7: A status write clears each of the bits 7, 2, 1 and 0 that is written as 1 in an enabled lane. An event that sets the same bit in the same cycle wins, and the bit ends set.
- R8: The line falls when a status write that clears at least one bit leaves that locality's status at zero and no event is recorded in the same cycle. Otherwise a raised line stays raised.
- R9: Selector 2 (vector) reads IRQ_NUM, which must lie in 0..15, in bits 3:0. Writes to it are ignored.
- R10: Writing 1 to bit 19 of the interface-ID register (selector 3, lane 2 enabled) from any locality sets the lock flag for every locality. Writing 0 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_valid | input | 1 | Some locality currently owns the interface |
| active_loc | input | LOC_W | Owning locality |
| ev_vld | input | 4 | Event pulses: data-available, status-valid, locality-changed, command-ready |
| ev_loc | input | 4*LOC_W | Target locality per event, event i in bits [i*LOC_W +: LOC_W] |
| reg_wr | input | 1 | Register write strobe |
| reg_loc | input | LOC_W | Locality issuing the write |
| reg_sel | input | 2 | Register: 0 enable, 1 status, 2 vector, 3 interface-ID |
| reg_be | input | 4 | Byte-lane enables of the write |
| reg_wdata | input | 32 | Write data |
| rd_loc | input | LOC_W | Locality of the read |
| rd_sel | input | 2 | Register read, same encoding as reg_sel |
| rd_data | output | 32 | Read data (combinational; 0 for enable/status of an invalid locality) |
| irq_o | output | 1 | Shared interrupt request, active high |

## Verification
The assertions run on every cycle and check four things. A rising line always follows an event pulse. A falling line always follows an owner's status write. Enable registers never change without an owner's enable write. The lock flag and the vector read stay fixed. Only the bench's scenarios can show the rest: the exact masks of the enable and status writes, the gating by global and individual enables, the OR-merging of simultaneous events, set winning over clear, and the rejection of events tagged with out-of-range localities. The bench compares every register of every locality against a model each cycle.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_IFACE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    localparam int          NUM_EV     = 4;
    localparam int          GLOBAL_BIT = 31;
    localparam int          LOCK_BIT   = 19;
    localparam logic [31:0] EV_MASK    = 32'h0000_0087;
    localparam logic [31:0] EN_WR_MASK = 32'h8000_009F;
    localparam logic [31:0] EN_RESET   = 32'h0000_0008;

    // Status/enable bit for event pulse index
    function automatic logic [31:0] ev_bit(input int idx);
        case (idx)
            0:       return 32'h0000_0001;
            1:       return 32'h0000_0002;
            2:       return 32'h0000_0004;
            default: return 32'h0000_0080;
        endcase
    endfunction

endpackage

// File: rtl/loc_irq_bank.sv
module loc_irq_bank
    import loc_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_wr,
    input  logic        sts_wr,
    input  logic [31:0] wdata,
    input  logic [31:0] lane_mask,
    input  logic [31:0] ev_req,
    output logic [31:0] en_q,
    output logic [31:0] sts_q,
    output logic        latched,
    output logic        zero_clear
);
    logic [31:0] gated;
    logic [31:0] clr;
    logic [31:0] en_d;
    logic [31:0] sts_d;

    always_comb begin
        gated      = en_q[GLOBAL_BIT] ? (ev_req & en_q & EV_MASK) : '0;
        clr        = sts_wr ? (wdata & lane_mask & EV_MASK) : '0;
        sts_d      = (sts_q & ~clr) | gated;
        en_d       = en_wr ? ((en_q & ~lane_mask) | (wdata & lane_mask & EN_WR_MASK)) : en_q;
        latched    = |gated;
        zero_clear = (|clr) && (sts_d == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= EN_RESET;
            sts_q <= '0;
        end else begin
            en_q  <= en_d;
            sts_q <= sts_d;
        end
    end

endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line
    import loc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_latch,
    input  logic any_zero_clear,
    output logic irq_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (any_latch) state_d = LINE_RAISED;
            LINE_RAISED: if (!any_latch && any_zero_clear) state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
    import loc_irq_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3,
    parameter int IRQ_NUM = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active_valid,
    input  logic [LOC_W-1:0]        active_loc,
    input  logic [3:0]              ev_vld,
    input  logic [4*LOC_W-1:0]      ev_loc,
    input  logic                    reg_wr,
    input  logic [LOC_W-1:0]        reg_loc,
    input  logic [1:0]              reg_sel,
    input  logic [3:0]              reg_be,
    input  logic [31:0]             reg_wdata,
    input  logic [LOC_W-1:0]        rd_loc,
    input  logic [1:0]              rd_sel,
    output logic [31:0]             rd_data,
    output logic                    irq_o
);
    localparam logic [LOC_W:0] NUM_LOC_V = (LOC_W+1)'(NUM_LOC);
    localparam logic [3:0]     IRQ_V     = 4'(IRQ_NUM);

    generate
        if (IRQ_NUM < 0 || IRQ_NUM > 15) begin : g_bad_irq
            $error("IRQ_NUM out of range 0..15");
        end
        if (NUM_LOC > (1 << LOC_W)) begin : g_bad_loc
            $error("NUM_LOC does not fit LOC_W");
        end
    endgenerate

    reg_sel_e                   wsel, rsel;
    logic                       wr_owner;
    logic [31:0]                lane_mask;
    logic [NUM_LOC-1:0][31:0]   en_pk;
    logic [NUM_LOC-1:0][31:0]   sts_pk;
    logic [NUM_LOC-1:0]         latch_v;
    logic [NUM_LOC-1:0]         zc_v;
    logic                       lock_q;

    always_comb begin
        wsel     = reg_sel_e'(reg_sel);
        rsel     = reg_sel_e'(rd_sel);
        wr_owner = active_valid && (reg_loc == active_loc) && ({1'b0, reg_loc} < NUM_LOC_V);
        for (int b = 0; b < 4; b++) lane_mask[b*8 +: 8] = {8{reg_be[b]}};
    end

    for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
        logic [31:0] req;
        logic        en_wr, sts_wr;

        always_comb begin
            req = '0;
            for (int e = 0; e < NUM_EV; e++) begin
                if (ev_vld[e] && (ev_loc[e*LOC_W +: LOC_W] == LOC_W'(l))) req = req | ev_bit(e);
            end
            en_wr  = reg_wr && wr_owner && (reg_loc == LOC_W'(l)) && (wsel == SEL_ENABLE);
            sts_wr = reg_wr && wr_owner && (reg_loc == LOC_W'(l)) && (wsel == SEL_STATUS);
        end

        loc_irq_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_wr      (en_wr),
            .sts_wr     (sts_wr),
            .wdata      (reg_wdata),
            .lane_mask  (lane_mask),
            .ev_req     (req),
            .en_q       (en_pk[l]),
            .sts_q      (sts_pk[l]),
            .latched    (latch_v[l]),
            .zero_clear (zc_v[l])
        );
    end

    loc_irq_line u_line (
        .clk            (clk),
        .rst_n          (rst_n),
        .any_latch      (|latch_v),
        .any_zero_clear (|zc_v),
        .irq_o          (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else if (reg_wr && wsel == SEL_IFACE && reg_be[2] && reg_wdata[LOCK_BIT]) lock_q <= 1'b1;
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_ENABLE: if ({1'b0, rd_loc} < NUM_LOC_V) rd_data = en_pk[rd_loc];
            SEL_STATUS: if ({1'b0, rd_loc} < NUM_LOC_V) rd_data = sts_pk[rd_loc];
            SEL_VECTOR: rd_data = {28'b0, IRQ_V};
            SEL_IFACE:  rd_data[LOCK_BIT] = lock_q;
        endcase
    end

endmodule

// File: rtl/loc_irq_chk.sv
module loc_irq_chk #(
    parameter int NUM_LOC = 5,
    parameter int IRQ_NUM = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   irq_o,
    input logic [3:0]             ev_vld,
    input logic                   reg_wr,
    input logic [1:0]             reg_sel,
    input logic                   owner,
    input logic [NUM_LOC*32-1:0]  en_flat,
    input logic                   lock_q,
    input logic [1:0]             rd_sel,
    input logic [31:0]            rd_data
);
    a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|ev_vld));

    a_r8_fall_needs_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(reg_wr && owner && reg_sel == 2'd1));

    a_r5_enable_only_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && owner && reg_sel == 2'd0) |=> $stable(en_flat));

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    a_r9_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel == 2'd2 |-> rd_data == 32'(IRQ_NUM));

endmodule

bind loc_irq_ctrl loc_irq_chk #(.NUM_LOC(NUM_LOC), .IRQ_NUM(IRQ_NUM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_o   (irq_o),
    .ev_vld  (ev_vld),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .owner   (wr_owner),
    .en_flat (en_pk),
    .lock_q  (lock_q),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
);

// File: tb/loc_irq_ctrl_test.sv
`timescale 1ns/100ps
module loc_irq_ctrl_test;
    localparam int NL = 5;
    localparam int IRQN = 10;

    logic        clk = 0, rst_n = 0;
    logic        active_valid = 0;
    logic [2:0]  active_loc = 0;
    logic [3:0]  ev_vld = 0;
    logic [11:0] ev_loc = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_loc = 0;
    logic [1:0]  reg_sel = 0;
    logic [3:0]  reg_be = 0;
    logic [31:0] reg_wdata = 0;
    logic [2:0]  rd_loc = 0;
    logic [1:0]  rd_sel = 0;
    logic [31:0] rd_data;
    logic        irq_o;

    int errors = 0, checks = 0;
    logic [31:0] m_en [NL];
    logic [31:0] m_sts [NL];
    logic        m_line, m_lock;

    always #2 clk = ~clk;

    loc_irq_ctrl #(.NUM_LOC(NL), .LOC_W(3), .IRQ_NUM(IRQN)) uut (
        .clk(clk), .rst_n(rst_n), .active_valid(active_valid), .active_loc(active_loc),
        .ev_vld(ev_vld), .ev_loc(ev_loc), .reg_wr(reg_wr), .reg_loc(reg_loc),
        .reg_sel(reg_sel), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o));

    function automatic logic [31:0] evb(int e);
        return (e == 3) ? 32'h80 : (32'h1 << e);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model step from the requirements, then clock once
    task automatic step();
        logic [31:0] en_n [NL];
        logic [31:0] sts_n [NL];
        logic [31:0] lm, req, gated, clr;
        logic any_l = 0, any_z = 0, own;
        for (int b = 0; b < 4; b++) lm[b*8 +: 8] = {8{reg_be[b]}};
        own = active_valid && reg_loc == active_loc && reg_loc < NL;
        for (int l = 0; l < NL; l++) begin
            req = 0;
            for (int e = 0; e < 4; e++)
                if (ev_vld[e] && ev_loc[e*3 +: 3] == 3'(l)) req |= evb(e);
            gated = m_en[l][31] ? (req & m_en[l] & 32'h87) : 0;
            en_n[l] = m_en[l];
            clr = 0;
            if (reg_wr && own && reg_loc == 3'(l) && reg_sel == 0)
                en_n[l] = (m_en[l] & ~lm) | (reg_wdata & lm & 32'h8000_009F);
            if (reg_wr && own && reg_loc == 3'(l) && reg_sel == 1)
                clr = reg_wdata & lm & 32'h87;
            sts_n[l] = (m_sts[l] & ~clr) | gated;
            if (gated != 0) any_l = 1;
            if (clr != 0 && sts_n[l] == 0) any_z = 1;
        end
        @(posedge clk);
        for (int l = 0; l < NL; l++) begin m_en[l] = en_n[l]; m_sts[l] = sts_n[l]; end
        if (any_l) m_line = 1; else if (any_z) m_line = 0;
        if (reg_wr && reg_sel == 3 && reg_be[2] && reg_wdata[19]) m_lock = 1;
        @(negedge clk);
        reg_wr = 0; ev_vld = 0;
    endtask

    task automatic rd(int l, int s);
        rd_loc = 3'(l); rd_sel = 2'(s); #0.1;
    endtask

    task automatic check_all(string ctx);
        for (int l = 0; l < NL; l++) begin
            rd(l, 0); chk({ctx, " R6 enable"}, rd_data, m_en[l]);
            rd(l, 1); chk({ctx, " R7 status"}, rd_data, m_sts[l]);
        end
        rd(6, 0); chk({ctx, " R3 invalid loc read"}, rd_data, 0);
        rd(0, 2); chk({ctx, " R9 vector"}, rd_data, IRQN);
        rd(2, 3); chk({ctx, " R10 lock"}, rd_data, {12'b0, m_lock, 19'b0});
        chk({ctx, " R8 line"}, {31'b0, irq_o}, {31'b0, m_line});
    endtask

    task automatic wr(int l, int s, logic [31:0] d, logic [3:0] be);
        reg_wr = 1; reg_loc = 3'(l); reg_sel = 2'(s); reg_wdata = d; reg_be = be;
    endtask

    task automatic ev(int e, int l);
        ev_vld[e] = 1; ev_loc[e*3 +: 3] = 3'(l);
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int l = 0; l < NL; l++) begin m_en[l] = 32'h8; m_sts[l] = 0; end
        m_line = 0; m_lock = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        active_valid = 1; active_loc = 1;
        wr(1, 2, 32'hFFFF_FFFF, 4'hF); step();
        rd(1, 2); chk("R9 vector write ignored", rd_data, IRQN);

        ev(0, 1); step();
        rd(1, 1); chk("R2 disabled event", rd_data, 0);

        wr(1, 0, 32'hFFFF_FF85, 4'h1); step();
        rd(1, 0); chk("R6 lane0 only", rd_data, 32'h85);
        ev(0, 1); step();
        rd(1, 1); chk("R2 no global enable", rd_data, 0);
        chk("R2 line low", {31'b0, irq_o}, 0);

        wr(1, 0, 32'hFFFF_FFFF, 4'hF); step();
        rd(1, 0); chk("R6 writable mask", rd_data, 32'h8000_009F);

        wr(2, 0, 32'h0, 4'hF); step();
        rd(2, 0); chk("R5 non-owner enable write", rd_data, 32'h8);

        ev(0, 1); ev(1, 1); ev(2, 1); ev(3, 1); step();
        rd(1, 1); chk("R4 merged events", rd_data, 32'h87);
        chk("R2 line raised", {31'b0, irq_o}, 1);

        wr(2, 1, 32'hFF, 4'h1); step();
        rd(1, 1); chk("R5 non-owner status write", rd_data, 32'h87);

        ev(0, 6); ev(3, 5); step();
        check_all("R3 invalid loc event");

        wr(1, 1, 32'h3, 4'h1); step();
        rd(1, 1); chk("R7 partial clear", rd_data, 32'h84);
        chk("R8 line stays", {31'b0, irq_o}, 1);

        wr(1, 1, 32'h85, 4'h1); ev(0, 1); step();
        rd(1, 1); chk("R7 set beats clear", rd_data, 32'h1);

        wr(1, 1, 32'h1, 4'h1); step();
        rd(1, 1); chk("R7 final clear", rd_data, 0);
        chk("R8 line drops", {31'b0, irq_o}, 0);

        wr(3, 3, 32'h0008_0000, 4'h4); step();
        rd(4, 3); chk("R10 lock shared", rd_data, 32'h0008_0000);
        wr(1, 3, 32'h0, 4'hF); step();
        rd(0, 3); chk("R10 lock sticky", rd_data, 32'h0008_0000);
        check_all("directed end");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                active_valid = ($urandom_range(0, 5) != 0);
                active_loc = 3'($urandom_range(0, 5));
            end
            ev_vld = 4'($urandom);
            ev_loc = 12'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom_range(0, 1) == 1) d = d | 32'h8000_0087;
                wr($urandom_range(0, 5), $urandom_range(0, 3), d, 4'($urandom));
            end
            step();
            check_all("random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule